// File: doc/BRIEF.md
# Serial-Bus Configuration Register File

This block is a two-wire serial-bus slave that holds a small bank of byte-wide configuration registers. It sits behind the system management bus of a clock-generation chip. A bus master uses it to read and to change the settings that the rest of the chip picks up from the flat register output. SCL and SDA arrive as plain inputs, and the block oversamples them with its own clock. It answers on the bus only by pulling SDA low, which gives open-drain behaviour.

The first byte after the slave address is a command byte. If its top bit is set, the command selects one register by the offset held in its low seven bits. If its top bit is clear, the command selects a block transfer that walks the bank from offset 0 upward. In that case the block transfer carries a byte count.

Writes pass through two protections:
- A write-enable bit in register 0, which only takes hold at the next block write.
- A write-once freeze bit, which locks the whole bank until the next reset.

Four bits of register 0 are loaded from strap pins just after reset.

Top module: `smbus_cfg_regfile`

## Requirements
- R1: The slave answers only to the 7-bit address 1101001 (D2h to write, D3h to read). Any other address gets no ACK, and SDA is never pulled for the rest of that transfer.
- R2: A write whose command byte has bit 7 = 1 stores the following data byte at the offset in command bits 6:0, subject to the locks of R7 to R10. Every byte of the transfer is ACKed.
- R3: A read that follows a command byte with bit 7 = 1 and a repeated start returns the register at that offset, most significant bit first.
- R4: A read that follows a command byte of 00h returns the count of implemented registers (8) first. It then returns registers from offset 0 upward until the master NACKs.
- R5: A block write (command 00h) takes a byte count and then stores data bytes at offsets 0, 1, 2 and so on. Data bytes beyond the count are ACKed but discarded.
- R6: Reset values are as follows. Register 0 holds the 4-bit strap in bits 4:1, with all other bits 0. Registers 1 and 2 hold FFh. Register 5 is read-only and holds 80h. All other registers hold 00h.
- R7: While the bank is locked, a write changes nothing except register 0 bit 0. The bank starts locked after reset.
- R8: The lock state is taken from register 0 bit 0 only when the byte count of a block write is received. Setting that bit therefore has no effect on other writes until the next block write.
- R9: Clearing register 0 bit 0 re-locks the bank from the next block write onward. Bit 0 itself stays writable.
- R10: Writing register 0 with bit 7 = 1 while unlocked freezes the bank until reset. Later writes are still ACKed but change no bit, bit 0 included.
- R11: Offsets 8 and above read as 00h, and writes to them are discarded.
- R12: A transfer that stops after any complete byte leaves the slave ready for the next transfer, with no register changed.

Only the write-enable bit of register 0 escapes the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| strap_fs | input | 4 | Strap pins loaded into register 0 bits 4:1 after reset |
| sda_pull_low | output | 1 | 1 = pull the SDA line low |
| cfg_bytes | output | NREG*8 | Register contents; offset i occupies bits i*8+7:i*8 |

## Verification
The bench first sweeps all sixteen strap values through reset. It then walks every offset, including the read-only ID byte and offsets past the bank. A design that ignored the strap, or let the ID byte or a missing register be written, shows a wrong byte at the flat output or on readback.

The lock tests target the deferred effect. They set the enable bit and then write another register before any block write, which must change nothing. They also check that a later block write re-locks the bank. A design that applied the enable bit at once would change a register early.

The freeze test writes bit 7 and then expects ACKs with no change. A block write longer than its count exposes a slave that keeps storing bytes past the count. A foreign address exposes a slave that ACKs transfers not meant for it.

// File: rtl/smbcfg_pkg.sv
package smbcfg_pkg;
  typedef enum logic [2:0] {
    LK_IDLE,
    LK_RX,
    LK_RX_ACK,
    LK_TX,
    LK_TX_ACK
  } link_state_e;

  typedef enum logic [1:0] {
    BR_ADDR,
    BR_CMD,
    BR_COUNT,
    BR_DATA
  } byte_role_e;

  localparam int OFFW = 7;
endpackage

// File: rtl/smb_pin_sampler.sv
module smb_pin_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_sync_q, sda_sync_q;
  logic [SYNC_STAGES-1:0] scl_sync_d, sda_sync_d;
  logic scl_prev_q, sda_prev_q;
  logic scl_s;

  always_comb begin
    scl_sync_d = {scl_sync_q[SYNC_STAGES-2:0], scl_in};
    sda_sync_d = {sda_sync_q[SYNC_STAGES-2:0], sda_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync_q <= '1;
      sda_sync_q <= '1;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_sync_q <= scl_sync_d;
      sda_sync_q <= sda_sync_d;
      scl_prev_q <= scl_s;
      sda_prev_q <= sda_s;
    end
  end

  assign scl_s     = scl_sync_q[SYNC_STAGES-1];
  assign sda_s     = sda_sync_q[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_prev_q;
  assign scl_fall  = ~scl_s & scl_prev_q;
  assign start_det = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
  assign stop_det  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;
endmodule

// File: rtl/smb_link.sv
module smb_link
  import smbcfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1101001,
  parameter int         NREG     = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sda,
  input  logic            scl_rise,
  input  logic            scl_fall,
  input  logic            start_det,
  input  logic            stop_det,
  input  logic [7:0]      rd_data,
  output logic [OFFW-1:0] rd_addr,
  output logic            wr_en,
  output logic [OFFW-1:0] wr_addr,
  output logic [7:0]      wr_data,
  output logic            cnt_arm,
  output logic            sda_low
);
  link_state_e     state_q, state_d;
  byte_role_e      role_q, role_d;
  logic [2:0]      bitcnt_q, bitcnt_d;
  logic [7:0]      shreg_q, shreg_d;
  logic [7:0]      cmd_q, cmd_d;
  logic [7:0]      cnt_q, cnt_d;
  logic [7:0]      done_q, done_d;
  logic [OFFW-1:0] ptr_q, ptr_d;
  logic            full_q, full_d;
  logic            go_tx_q, go_tx_d;
  logic            first_q, first_d;
  logic            nack_q, nack_d;
  logic            sda_low_q, sda_low_d;
  logic [7:0]      tx_val;
  logic            tx_is_count;

  assign tx_is_count = first_q & ~cmd_q[7];
  assign tx_val      = tx_is_count ? 8'(NREG) : rd_data;
  assign rd_addr     = ptr_q;
  assign wr_addr     = ptr_q;
  assign wr_data     = shreg_q;
  assign sda_low     = sda_low_q;

  always_comb begin
    state_d   = state_q;
    role_d    = role_q;
    bitcnt_d  = bitcnt_q;
    shreg_d   = shreg_q;
    cmd_d     = cmd_q;
    cnt_d     = cnt_q;
    done_d    = done_q;
    ptr_d     = ptr_q;
    full_d    = full_q;
    go_tx_d   = go_tx_q;
    first_d   = first_q;
    nack_d    = nack_q;
    sda_low_d = sda_low_q;
    wr_en     = 1'b0;
    cnt_arm   = 1'b0;

    if (start_det) begin
      state_d   = LK_RX;
      role_d    = BR_ADDR;
      bitcnt_d  = '0;
      full_d    = 1'b0;
      sda_low_d = 1'b0;
    end else if (stop_det) begin
      state_d   = LK_IDLE;
      sda_low_d = 1'b0;
    end else begin
      unique case (state_q)
        LK_RX: begin
          if (scl_rise && !full_q) begin
            shreg_d  = {shreg_q[6:0], sda};
            bitcnt_d = bitcnt_q + 3'd1;
            full_d   = (bitcnt_q == 3'd7);
          end else if (scl_fall && full_q) begin
            full_d    = 1'b0;
            sda_low_d = 1'b1;
            state_d   = LK_RX_ACK;
            go_tx_d   = 1'b0;
            unique case (role_q)
              BR_ADDR: begin
                if (shreg_q[7:1] == DEV_ADDR) begin
                  if (shreg_q[0]) begin
                    go_tx_d = 1'b1;
                    first_d = 1'b1;
                    ptr_d   = cmd_q[7] ? cmd_q[6:0] : '0;
                  end else begin
                    role_d = BR_CMD;
                  end
                end else begin
                  sda_low_d = 1'b0;
                  state_d   = LK_IDLE;
                end
              end
              BR_CMD: begin
                cmd_d  = shreg_q;
                ptr_d  = shreg_q[7] ? shreg_q[6:0] : '0;
                role_d = shreg_q[7] ? BR_DATA : BR_COUNT;
                done_d = '0;
              end
              BR_COUNT: begin
                cnt_d   = shreg_q;
                cnt_arm = 1'b1;
                role_d  = BR_DATA;
              end
              BR_DATA: begin
                wr_en = cmd_q[7] | (done_q < cnt_q);
                ptr_d = ptr_q + 1'b1;
                if (done_q != 8'hFF) done_d = done_q + 8'd1;
              end
              default: ;
            endcase
          end
        end
        LK_RX_ACK: begin
          if (scl_fall) begin
            bitcnt_d = '0;
            if (go_tx_q) begin
              shreg_d   = tx_val;
              sda_low_d = ~tx_val[7];
              state_d   = LK_TX;
              first_d   = 1'b0;
              if (!tx_is_count) ptr_d = ptr_q + 1'b1;
            end else begin
              sda_low_d = 1'b0;
              state_d   = LK_RX;
            end
          end
        end
        LK_TX: begin
          if (scl_fall) begin
            if (bitcnt_q == 3'd7) begin
              sda_low_d = 1'b0;
              state_d   = LK_TX_ACK;
            end else begin
              shreg_d   = {shreg_q[6:0], 1'b0};
              sda_low_d = ~shreg_q[6];
              bitcnt_d  = bitcnt_q + 3'd1;
            end
          end
        end
        LK_TX_ACK: begin
          if (scl_rise) begin
            nack_d = sda;
          end else if (scl_fall) begin
            bitcnt_d = '0;
            if (nack_q) begin
              state_d = LK_IDLE;
            end else begin
              shreg_d   = tx_val;
              sda_low_d = ~tx_val[7];
              state_d   = LK_TX;
              first_d   = 1'b0;
              if (!tx_is_count) ptr_d = ptr_q + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= LK_IDLE;
      role_q    <= BR_ADDR;
      bitcnt_q  <= '0;
      shreg_q   <= '0;
      cmd_q     <= '0;
      cnt_q     <= '0;
      done_q    <= '0;
      ptr_q     <= '0;
      full_q    <= 1'b0;
      go_tx_q   <= 1'b0;
      first_q   <= 1'b0;
      nack_q    <= 1'b0;
      sda_low_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      role_q    <= role_d;
      bitcnt_q  <= bitcnt_d;
      shreg_q   <= shreg_d;
      cmd_q     <= cmd_d;
      cnt_q     <= cnt_d;
      done_q    <= done_d;
      ptr_q     <= ptr_d;
      full_q    <= full_d;
      go_tx_q   <= go_tx_d;
      first_q   <= first_d;
      nack_q    <= nack_d;
      sda_low_q <= sda_low_d;
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LK_IDLE) |-> !sda_low_q);

  p_write_acked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> sda_low_q);

  p_tx_bit_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LK_TX && !scl_fall && !start_det && !stop_det) |=> $stable(sda_low_q));
endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
  import smbcfg_pkg::*;
#(
  parameter int         NREG   = 8,
  parameter int         ID_OFF = 5,
  parameter logic [7:0] ID_VAL = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        strap,
  input  logic              wr_en,
  input  logic [OFFW-1:0]   wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              cnt_arm,
  input  logic [OFFW-1:0]   rd_addr,
  output logic [7:0]        rd_data,
  output logic [NREG*8-1:0] cfg_flat
);
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;

  logic [7:0] regs_q [NREG];
  logic [7:0] regs_d [NREG];
  logic [NREG-1:0] ld_en;
  logic unlock_q, strap_done_q;
  logic frozen;

  assign frozen = regs_q[0][7];

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      regs_d[i] = regs_q[i];
      ld_en[i]  = 1'b0;
      if (wr_en && !frozen && (wr_addr == OFFW'(i))) begin
        if (i == 0) begin
          ld_en[i] = 1'b1;
          if (unlock_q) regs_d[i] = wr_data;
          else          regs_d[i][0] = wr_data[0];
        end else if (unlock_q && i != ID_OFF) begin
          ld_en[i]  = 1'b1;
          regs_d[i] = wr_data;
        end
      end
      if (i == 0 && !strap_done_q) begin
        ld_en[i]       = 1'b1;
        regs_d[i][4:1] = strap;
      end
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [7:0] RST = (g == ID_OFF) ? ID_VAL :
                                 ((g == 1) || (g == 2)) ? 8'hFF : 8'h00;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          regs_q[g] <= RST;
      else if (ld_en[g])   regs_q[g] <= regs_d[g];
    end
    assign cfg_flat[g*8 +: 8] = regs_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlock_q     <= 1'b0;
      strap_done_q <= 1'b0;
    end else begin
      strap_done_q <= 1'b1;
      if (cnt_arm) unlock_q <= regs_q[0][0];
    end
  end

  assign rd_data = (rd_addr < OFFW'(NREG)) ? regs_q[rd_addr[IW-1:0]] : 8'h00;

  p_locked_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_done_q && !unlock_q) |=> $stable(cfg_flat[NREG*8-1:1]));

  p_freeze_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_flat[7] |=> cfg_flat[7]);

  p_freeze_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_done_q && cfg_flat[7]) |=> $stable(cfg_flat));
endmodule

// File: rtl/smbus_cfg_regfile.sv
module smbus_cfg_regfile
  import smbcfg_pkg::*;
#(
  parameter int         NREG        = 8,
  parameter int         ID_OFF      = 5,
  parameter logic [7:0] ID_VAL      = 8'h80,
  parameter logic [6:0] DEV_ADDR    = 7'b1101001,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [3:0]        strap_fs,
  output logic              sda_pull_low,
  output logic [NREG*8-1:0] cfg_bytes
);
  logic [1:0] rst_sync_q;
  logic rst_core_n;
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [7:0] rd_data, wr_data;
  logic [OFFW-1:0] rd_addr, wr_addr;
  logic wr_en, cnt_arm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  smb_pin_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst_n(rst_core_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  smb_link #(.DEV_ADDR(DEV_ADDR), .NREG(NREG)) u_link (
    .clk(clk), .rst_n(rst_core_n), .sda(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cnt_arm(cnt_arm), .sda_low(sda_pull_low)
  );

  smb_reg_bank #(.NREG(NREG), .ID_OFF(ID_OFF), .ID_VAL(ID_VAL)) u_bank (
    .clk(clk), .rst_n(rst_core_n), .strap(strap_fs),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cnt_arm(cnt_arm), .rd_addr(rd_addr), .rd_data(rd_data),
    .cfg_flat(cfg_bytes)
  );
endmodule

// File: tb/smbus_cfg_regfile_test.sv
module smbus_cfg_regfile_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 8;
  localparam int NREG       = 8;
  localparam int MAX_CYC    = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic [3:0] strap = 4'h0;
  logic sda_pull;
  logic [NREG*8-1:0] cfg;
  logic sda_line;

  int vectors = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [7:0] m_reg [NREG];
  bit m_unlock;
  logic [7:0] bw [8];

  assign sda_line = sda_m & ~sda_pull;

  always #(CLK_PERIOD/2) clk = ~clk;

  smbus_cfg_regfile uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
    .strap_fs(strap), .sda_pull_low(sda_pull), .cfg_bytes(cfg)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] m_read(int off);
    return (off < NREG) ? m_reg[off] : 8'h00;
  endfunction

  task automatic m_write(int off, logic [7:0] v);
    if (m_reg[0][7]) return;
    if (off == 0) begin
      if (m_unlock) m_reg[0] = v;
      else          m_reg[0][0] = v[0];
    end else if (m_unlock && off < NREG && off != 5) begin
      m_reg[off] = v;
    end
  endtask

  task automatic check_all(string req);
    for (int i = 0; i < NREG; i++) chk(req, cfg[i*8 +: 8], m_reg[i]);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; tick(Q);
    scl = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic put_byte(logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl = 1'b1; tick(Q);
      scl = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q);
    scl = 1'b1; tick(Q);
    ack = ~sda_line;
    scl = 1'b0; tick(Q);
  endtask

  task automatic get_byte(bit nack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; tick(Q);
      scl = 1'b1; tick(Q);
      b[i] = sda_line;
      scl = 1'b0;
    end
    tick(Q / 2);
    sda_m = nack; tick(Q);
    scl = 1'b1; tick(Q);
    scl = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic byte_write(int off, logic [7:0] v);
    logic a;
    bus_start();
    put_byte(8'hD2, a); chk("R2 addr ack", 8'(a), 8'h01);
    put_byte({1'b1, 7'(off)}, a); chk("R2 cmd ack", 8'(a), 8'h01);
    put_byte(v, a); chk("R2 data ack", 8'(a), 8'h01);
    bus_stop();
    m_write(off, v);
  endtask

  task automatic byte_read(int off, string req);
    logic a;
    logic [7:0] d;
    bus_start();
    put_byte(8'hD2, a); chk("R3 addr ack", 8'(a), 8'h01);
    put_byte({1'b1, 7'(off)}, a); chk("R3 cmd ack", 8'(a), 8'h01);
    bus_rstart();
    put_byte(8'hD3, a); chk("R3 read addr ack", 8'(a), 8'h01);
    get_byte(1'b1, d);
    bus_stop();
    chk(req, d, m_read(off));
  endtask

  task automatic block_write(logic [7:0] cnt, int n);
    logic a;
    bus_start();
    put_byte(8'hD2, a); chk("R5 addr ack", 8'(a), 8'h01);
    put_byte(8'h00, a); chk("R5 cmd ack", 8'(a), 8'h01);
    put_byte(cnt, a); chk("R5 count ack", 8'(a), 8'h01);
    m_unlock = m_reg[0][0];
    for (int k = 0; k < n; k++) begin
      put_byte(bw[k], a); chk("R5 data ack", 8'(a), 8'h01);
      if (k < cnt) m_write(k, bw[k]);
    end
    bus_stop();
  endtask

  task automatic block_read(int n);
    logic a;
    logic [7:0] d;
    bus_start();
    put_byte(8'hD2, a); chk("R4 addr ack", 8'(a), 8'h01);
    put_byte(8'h00, a); chk("R4 cmd ack", 8'(a), 8'h01);
    bus_rstart();
    put_byte(8'hD3, a); chk("R4 read addr ack", 8'(a), 8'h01);
    for (int k = 0; k < n; k++) begin
      get_byte(k == n - 1, d);
      if (k == 0) chk("R4 count", d, 8'(NREG));
      else        chk("R4 data", d, m_read(k - 1));
    end
    bus_stop();
  endtask

  task automatic do_reset(logic [3:0] s);
    strap = s;
    rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(6);
    for (int i = 0; i < NREG; i++) m_reg[i] = 8'h00;
    m_reg[0] = {3'b000, s, 1'b0};
    m_reg[1] = 8'hFF;
    m_reg[2] = 8'hFF;
    m_reg[5] = 8'h80;
    m_unlock = 1'b0;
  endtask

  initial begin : watchdog
    repeat (MAX_CYC) @(posedge clk);
    if (!finished) begin
      fails++;
      vectors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin : stim
    logic a;
    // R6: reset values under every strap setting
    for (int s = 0; s < 16; s++) begin
      do_reset(4'(s));
      check_all("R6 reset value");
      chk("R6 sda idle", 8'(sda_pull), 8'h00);
    end

    // R1: foreign addresses get no ACK and SDA stays released
    bus_start();
    put_byte(8'hA4, a); chk("R1 foreign addr nack", 8'(a), 8'h00);
    put_byte(8'h83, a); chk("R1 no ack after foreign addr", 8'(a), 8'h00);
    bus_stop();
    bus_start();
    put_byte(8'hD0, a); chk("R1 neighbour addr nack", 8'(a), 8'h00);
    bus_stop();
    check_all("R1 no change");

    // R7: locked after reset
    byte_write(3, 8'h5A);
    byte_write(1, 8'h00);
    check_all("R7 locked write ignored");

    // R8: enable bit set but not yet applied
    byte_write(0, 8'h01);
    byte_write(3, 8'hA5);
    check_all("R8 deferred unlock");

    // R8/R5: block write arms the unlock
    bw[0] = 8'h01; bw[1] = 8'h11; bw[2] = 8'h22;
    block_write(8'd3, 3);
    check_all("R8 unlocked by block write");

    // R2/R11: write sweep across all offsets, then readback sweep (R3)
    for (int off = 1; off < 10; off++) byte_write(off, 8'(8'h30 + off));
    check_all("R2 write sweep");
    for (int off = 0; off < 10; off++) byte_read(off, "R3 read sweep");
    byte_read(9, "R11 unimplemented read");

    // R2: walking-one pattern on one register
    for (int b = 0; b < 8; b++) begin
      byte_write(6, 8'(1 << b));
      byte_read(6, "R3 walking one");
    end

    // R5: bytes beyond count are discarded
    bw[0] = 8'h01; bw[1] = 8'h5C; bw[2] = 8'hC3; bw[3] = 8'hEE;
    block_write(8'd2, 4);
    check_all("R5 count limit");

    // R4: block read including one past the bank
    block_read(NREG + 2);

    // R12: stop after command byte
    bus_start();
    put_byte(8'hD2, a); chk("R12 addr ack", 8'(a), 8'h01);
    put_byte(8'h83, a); chk("R12 cmd ack", 8'(a), 8'h01);
    bus_stop();
    check_all("R12 no change after early stop");
    byte_read(3, "R12 next transfer");

    // R9: clear enable, still unlocked until next block write
    byte_write(0, 8'h00);
    byte_write(3, 8'h77);
    check_all("R9 relock deferred");
    bw[0] = 8'h00;
    block_write(8'd1, 1);
    byte_write(3, 8'h99);
    check_all("R9 relocked");
    byte_write(0, 8'h01);
    check_all("R9 enable bit writable");

    // R10: freeze
    bw[0] = 8'h01;
    block_write(8'd1, 1);
    byte_write(0, 8'h81);
    check_all("R10 freeze set");
    byte_write(1, 8'h44);
    byte_write(0, 8'h00);
    bw[0] = 8'h00; bw[1] = 8'h12;
    block_write(8'd2, 2);
    check_all("R10 frozen");
    byte_read(0, "R10 frozen readback");

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule